// File: doc/BRIEF.md
# PSRAM Power-Up Configuration Sequencer

This block takes a pseudo-static RAM from the moment its supply is reported good to the point where it is configured and usable. It first holds the device's mode pin low for a long settling interval, keeps chip-select deasserted while the mode pin is raised, and then waits a further interval before the first access is allowed. It then unlocks and writes the device's configuration register. The unlock is a fixed train of five accesses: three reads at the topmost address, whose returned data is ignored, followed by two writes that carry two configuration words.

All delays are given in nanoseconds as parameters and are turned into clock cycles from a clock-frequency parameter. Each delay is rounded up to whole cycles, and one extra cycle is added as margin. A build-time option removes the mode-pin phase for devices that need only a plain wait after power-good; in that variant the mode pin is tied high. The configuration address and data words come in as inputs and are captured when the sequence starts. A ready flag tells the rest of the memory subsystem when normal traffic may begin.

Top module: `psram_cfg_sequencer`

## Requirements
- R1: While `rst_n` is low, and immediately on its falling edge without waiting for a clock, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `cfg_ready` is 0 and `mem_mode` is 0 (normal variant).
- R2: After reset, as long as `pwr_good` is 0, the controller stays idle: no access is started, `mem_mode` stays 0 and `cfg_ready` stays 0.
- R3: Every delay D ns is applied as N(D) = ceil(D*CLK_MHZ/1000)+1 cycles. Take the first clock edge that samples `pwr_good` high as edge 1. `mem_mode` is 0 through the first N(T_MODE_LOW_NS)+N(T_CS_SETUP_NS) cycles and rises after the next edge. `mem_cs_n` stays 1 throughout this time.
- R4: After `mem_mode` rises, `mem_cs_n` stays 1 for exactly N(T_MODE_WAIT_NS) cycles before the first access.
- R5: Exactly five accesses follow, in this order. The first three are reads (`mem_oe_n`=0, `mem_we_n`=1) at address all-ones (0x1FFFFF for 21 bits). The last two are writes (`mem_we_n`=0, `mem_oe_n`=1) to `cfg_addr`, carrying `cfg_data0` first and then `cfg_data1` on `mem_wdata`. A strobe is only ever low while `mem_cs_n` is 0, and never both strobes at once.
- R6: Each access holds `mem_cs_n` at 0 for exactly N(T_ACC_NS) cycles, with address and strobe steady throughout.
- R7: Between consecutive accesses, `mem_cs_n` returns to 1 for exactly N(T_GAP_NS) cycles.
- R8: `cfg_ready` rises in the same cycle that `mem_cs_n` returns to 1 after the fifth access. It then stays 1 with all strobes and chip-select high until reset.
- R9: `cfg_addr`, `cfg_data0` and `cfg_data1` are captured at edge 1; later changes have no effect on the writes.
- R10: With SKIP_MODE_SEQ=1, `mem_mode` is 1 at all times, including reset. The first access starts exactly N(T_SKIP_WAIT_NS) cycles after edge 1; all other timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | High once the memory supply has reached its minimum |
| cfg_addr | input | ADDR_W | Address used by the two configuration writes |
| cfg_data0 | input | DATA_W | First configuration word |
| cfg_data1 | input | DATA_W | Second configuration word |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_mode | output | 1 | Mode pin, held low during power-up |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| cfg_ready | output | 1 | Configuration finished; normal access allowed |

## Verification
The full pin trace is checked cycle by cycle against a timeline the bench builds from the delay formula. This is done for several configuration vectors: all-zero against all-one words, alternating bit patterns, and the write address equal to or far from the unlock address. The vectors separate swapped or stuck write data and a write aimed at the wrong address. Each vector changes the configuration inputs mid-sequence, which exposes a missing capture. A second instance built with the skip option runs beside the first to show the shortened path and the tied mode pin. Directed cases cover idling with power-good low and an asynchronous reset landing in the middle of a read.

// File: rtl/psram_seq_pkg.sv
`timescale 1ns/1ps
package psram_seq_pkg;

  typedef enum logic [3:0] {
    ST_WAIT_PWR,
    ST_MODE_LOW,
    ST_CS_HIGH,
    ST_MODE_HIGH_WAIT,
    ST_ACC0,
    ST_GAP0,
    ST_ACC1,
    ST_GAP1,
    ST_ACC2,
    ST_GAP2,
    ST_ACC3,
    ST_GAP3,
    ST_ACC4,
    ST_DONE
  } seq_state_e;

  // Minimum delay in ns -> cycles, rounded up, plus one cycle of margin.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000 + 1;
  endfunction

  function automatic logic st_is_access(seq_state_e s);
    return s inside {ST_ACC0, ST_ACC1, ST_ACC2, ST_ACC3, ST_ACC4};
  endfunction

  // The last two accesses of the unlock train are writes.
  function automatic logic st_is_write(seq_state_e s);
    return s inside {ST_ACC3, ST_ACC4};
  endfunction

  function automatic logic st_mode_high(seq_state_e s);
    return !(s inside {ST_WAIT_PWR, ST_MODE_LOW, ST_CS_HIGH});
  endfunction

endpackage

// File: rtl/psram_seq_rst_sync.sv
`timescale 1ns/1ps
module psram_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/psram_seq_timer.sv
`timescale 1ns/1ps
module psram_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_seq_pins.sv
`timescale 1ns/1ps
module psram_seq_pins
  import psram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 21,
  parameter int unsigned DATA_W        = 16,
  parameter bit          SKIP_MODE_SEQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              cfg_capture,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data0,
  input  logic [DATA_W-1:0] cfg_data1,
  output logic              mem_cs_n,
  output logic              mem_mode,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cfg_ready
);

  localparam logic [ADDR_W-1:0] UNLOCK_ADDR = {ADDR_W{1'b1}};

  // Captured configuration
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_d0_q, lat_d1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      lat_d0_q   <= '0;
      lat_d1_q   <= '0;
    end else if (cfg_capture) begin
      lat_addr_q <= cfg_addr;
      lat_d0_q   <= cfg_data0;
      lat_d1_q   <= cfg_data1;
    end
  end

  // Pin decode from the next state, registered so the pins never glitch
  logic              cs_n_q, oe_n_q, we_n_q, rdy_q;
  logic              cs_n_d, oe_n_d, we_n_d, rdy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              acc_d, wr_d, wdata_en;

  always_comb begin
    acc_d    = st_is_access(state_d);
    wr_d     = st_is_write(state_d);
    cs_n_d   = !acc_d;
    oe_n_d   = !(acc_d && !wr_d);
    we_n_d   = !(acc_d && wr_d);
    rdy_d    = (state_d == ST_DONE);
    addr_d   = wr_d ? lat_addr_q : UNLOCK_ADDR;
    wdata_en = wr_d;
    wdata_d  = (state_d == ST_ACC3) ? lat_d0_q : lat_d1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      cs_n_q <= cs_n_d;
      oe_n_q <= oe_n_d;
      we_n_q <= we_n_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (acc_d) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= wdata_d;
    end
  end

  generate
    if (SKIP_MODE_SEQ) begin : g_mode_tied
      assign mem_mode = 1'b1;
    end else begin : g_mode_seq
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q <= 1'b0;
        end else begin
          mode_q <= st_mode_high(state_d);
        end
      end
      assign mem_mode = mode_q;

      // R3: an access is never issued while the mode pin is still low
      assert_access_after_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> mem_mode);
    end
  endgenerate

  assign mem_cs_n  = cs_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign cfg_ready = rdy_q;

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_strobe_in_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  assert_access_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_oe_n) && $stable(mem_we_n)));

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);

  assert_ready_bus_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (mem_cs_n && mem_oe_n && mem_we_n));

endmodule

// File: rtl/psram_cfg_sequencer.sv
`timescale 1ns/1ps
module psram_cfg_sequencer
  import psram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ         = 250,
  parameter int unsigned ADDR_W          = 21,
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned T_MODE_LOW_NS   = 500000,
  parameter int unsigned T_CS_SETUP_NS   = 50,
  parameter int unsigned T_MODE_WAIT_NS  = 10000,
  parameter int unsigned T_ACC_NS        = 70,
  parameter int unsigned T_GAP_NS        = 10,
  parameter int unsigned T_SKIP_WAIT_NS  = 200000,
  parameter bit          SKIP_MODE_SEQ   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data0,
  input  logic [DATA_W-1:0] cfg_data1,
  output logic              mem_cs_n,
  output logic              mem_mode,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cfg_ready
);

  localparam int unsigned L_MODE_LOW = ns_to_cycles(T_MODE_LOW_NS, CLK_MHZ);
  localparam int unsigned L_CS_SETUP = ns_to_cycles(T_CS_SETUP_NS, CLK_MHZ);
  localparam int unsigned L_WAIT     = SKIP_MODE_SEQ ? ns_to_cycles(T_SKIP_WAIT_NS, CLK_MHZ)
                                                     : ns_to_cycles(T_MODE_WAIT_NS, CLK_MHZ);
  localparam int unsigned L_ACC      = ns_to_cycles(T_ACC_NS, CLK_MHZ);
  localparam int unsigned L_GAP      = ns_to_cycles(T_GAP_NS, CLK_MHZ);
  localparam int unsigned L_MAX_A    = (L_MODE_LOW > L_CS_SETUP) ? L_MODE_LOW : L_CS_SETUP;
  localparam int unsigned L_MAX_B    = (L_WAIT > L_ACC) ? L_WAIT : L_ACC;
  localparam int unsigned L_MAX_C    = (L_MAX_A > L_MAX_B) ? L_MAX_A : L_MAX_B;
  localparam int unsigned L_MAX      = (L_MAX_C > L_GAP) ? L_MAX_C : L_GAP;
  localparam int unsigned CNT_W      = $clog2(L_MAX + 1);

  logic             rst_sync_n;
  seq_state_e       state_q, state_d;
  logic             timer_load, timer_done, cfg_capture;
  logic [CNT_W-1:0] timer_val;

  psram_seq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_PWR:       if (pwr_good)   state_d = SKIP_MODE_SEQ ? ST_MODE_HIGH_WAIT : ST_MODE_LOW;
      ST_MODE_LOW:       if (timer_done) state_d = ST_CS_HIGH;
      ST_CS_HIGH:        if (timer_done) state_d = ST_MODE_HIGH_WAIT;
      ST_MODE_HIGH_WAIT: if (timer_done) state_d = ST_ACC0;
      ST_DONE:                           state_d = ST_DONE;
      default:           if (timer_done) state_d = seq_state_e'(state_q + 4'd1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_WAIT_PWR;
    end else begin
      state_q <= state_d;
    end
  end

  // Each timed state lasts exactly its cycle count: load count-1 on entry.
  always_comb begin
    timer_load  = (state_d != state_q);
    cfg_capture = (state_q == ST_WAIT_PWR) && pwr_good;
    unique case (state_d)
      ST_MODE_LOW:       timer_val = CNT_W'(L_MODE_LOW - 1);
      ST_CS_HIGH:        timer_val = CNT_W'(L_CS_SETUP - 1);
      ST_MODE_HIGH_WAIT: timer_val = CNT_W'(L_WAIT - 1);
      ST_ACC0, ST_ACC1, ST_ACC2, ST_ACC3, ST_ACC4:
                         timer_val = CNT_W'(L_ACC - 1);
      ST_GAP0, ST_GAP1, ST_GAP2, ST_GAP3:
                         timer_val = CNT_W'(L_GAP - 1);
      default:           timer_val = '0;
    endcase
  end

  psram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_done)
  );

  psram_seq_pins #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .SKIP_MODE_SEQ (SKIP_MODE_SEQ)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state_d     (state_d),
    .cfg_capture (cfg_capture),
    .cfg_addr    (cfg_addr),
    .cfg_data0   (cfg_data0),
    .cfg_data1   (cfg_data1),
    .mem_cs_n    (mem_cs_n),
    .mem_mode    (mem_mode),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .cfg_ready   (cfg_ready)
  );

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_WAIT_PWR) |-> (mem_cs_n && !cfg_ready));

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DONE) |-> cfg_ready);

endmodule

// File: tb/psram_cfg_sequencer_bench.sv
`timescale 1ns/1ps
module psram_cfg_sequencer_bench;

  localparam int CLK_MHZ = 250;
  localparam int ADDR_W  = 21;
  localparam int DATA_W  = 16;
  localparam int T_ML    = 400;
  localparam int T_CS    = 50;
  localparam int T_MW    = 200;
  localparam int T_ACC   = 70;
  localparam int T_GAP   = 10;
  localparam int T_SKIP  = 300;

  function automatic int cyc_of(int ns);
    return (ns * CLK_MHZ + 999) / 1000 + 1;
  endfunction

  localparam int L_ML   = cyc_of(T_ML);
  localparam int L_CS   = cyc_of(T_CS);
  localparam int L_MW   = cyc_of(T_MW);
  localparam int L_ACC  = cyc_of(T_ACC);
  localparam int L_GAP  = cyc_of(T_GAP);
  localparam int L_SKIP = cyc_of(T_SKIP);
  localparam int B2N    = L_ML + L_CS;
  localparam int B3N    = B2N + L_MW;
  localparam int SLOT   = L_ACC + L_GAP;
  localparam int RUN_K  = B3N + 5 * SLOT + 10;
  localparam logic [ADDR_W-1:0] UNLOCK = 21'h1FFFFF;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] d0;
    logic [DATA_W-1:0] d1;
    logic [ADDR_W-1:0] addr_alt;
    logic [DATA_W-1:0] d0_alt;
    logic [DATA_W-1:0] d1_alt;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{21'h000000, 16'h0000, 16'hFFFF, 21'h1FFFFF, 16'hFFFF, 16'h0000},
    '{21'h1FFFFF, 16'hA5A5, 16'h5A5A, 21'h000000, 16'h5A5A, 16'hA5A5},
    '{21'h0ABCDE, 16'h1234, 16'h8001, 21'h154321, 16'hEDCB, 16'h7FFE},
    '{21'h100001, 16'hFFFF, 16'h0000, 21'h0FFFFE, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_good;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_data0, cfg_data1;

  logic              n_cs_n, n_mode, n_oe_n, n_we_n, n_rdy;
  logic [ADDR_W-1:0] n_addr;
  logic [DATA_W-1:0] n_wdata;
  logic              s_cs_n, s_mode, s_oe_n, s_we_n, s_rdy;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  psram_cfg_sequencer #(
    .CLK_MHZ(CLK_MHZ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .T_MODE_LOW_NS(T_ML), .T_CS_SETUP_NS(T_CS), .T_MODE_WAIT_NS(T_MW),
    .T_ACC_NS(T_ACC), .T_GAP_NS(T_GAP), .T_SKIP_WAIT_NS(T_SKIP), .SKIP_MODE_SEQ(1'b0)
  ) u_psram_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .cfg_addr(cfg_addr), .cfg_data0(cfg_data0), .cfg_data1(cfg_data1),
    .mem_cs_n(n_cs_n), .mem_mode(n_mode), .mem_oe_n(n_oe_n), .mem_we_n(n_we_n),
    .mem_addr(n_addr), .mem_wdata(n_wdata), .cfg_ready(n_rdy)
  );

  psram_cfg_sequencer #(
    .CLK_MHZ(CLK_MHZ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .T_MODE_LOW_NS(T_ML), .T_CS_SETUP_NS(T_CS), .T_MODE_WAIT_NS(T_MW),
    .T_ACC_NS(T_ACC), .T_GAP_NS(T_GAP), .T_SKIP_WAIT_NS(T_SKIP), .SKIP_MODE_SEQ(1'b1)
  ) u_psram_cfg_sequencer_skip (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .cfg_addr(cfg_addr), .cfg_data0(cfg_data0), .cfg_data1(cfg_data1),
    .mem_cs_n(s_cs_n), .mem_mode(s_mode), .mem_oe_n(s_oe_n), .mem_we_n(s_we_n),
    .mem_addr(s_addr), .mem_wdata(s_wdata), .cfg_ready(s_rdy)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected pins k cycles after the first edge that samples pwr_good high.
  task automatic check_at(input int k, input bit skip, input vec_t v,
                          input logic cs, input logic oe, input logic we,
                          input logic mode, input logic rdy,
                          input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd);
    int b2, b3, off, s, p, slot;
    logic e_cs, e_oe, e_we, e_mode, e_rdy;
    string tag;
    b2 = skip ? 0 : B2N;
    b3 = skip ? L_SKIP : B3N;
    e_cs = 1'b1; e_oe = 1'b1; e_we = 1'b1; e_rdy = 1'b0;
    e_mode = skip ? 1'b1 : (k > b2);
    slot = -1;
    if (k <= b2) tag = "R3";
    else if (k <= b3) tag = skip ? "R10" : "R4";
    else begin
      off = k - b3 - 1;
      s = off / SLOT;
      p = off % SLOT;
      if (s <= 4 && p < L_ACC) begin
        slot = s; e_cs = 1'b0; tag = "R5/R6";
        if (s < 3) e_oe = 1'b0; else e_we = 1'b0;
      end else if (s < 4) tag = "R7";
      else begin e_rdy = 1'b1; tag = "R8"; end
    end
    chk(tag, "cs_n", 32'(cs), 32'(e_cs));
    chk(tag, "oe_n", 32'(oe), 32'(e_oe));
    chk(tag, "we_n", 32'(we), 32'(e_we));
    chk(tag, "ready", 32'(rdy), 32'(e_rdy));
    chk(skip ? "R10" : "R3", "mode", 32'(mode), 32'(e_mode));
    if (slot >= 0 && slot < 3) chk("R5", "read addr", 32'(addr), 32'(UNLOCK));
    if (slot >= 3) chk("R9", "write addr", 32'(addr), 32'(v.addr));
    if (slot == 3) chk("R9", "wdata0", 32'(wd), 32'(v.d0));
    if (slot == 4) chk("R9", "wdata1", 32'(wd), 32'(v.d1));
  endtask

  task automatic reset_and_release(input vec_t v);
    pwr_good = 1'b0;
    rst_n = 1'b0;
    cfg_addr = v.addr; cfg_data0 = v.d0; cfg_data1 = v.d1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_row(input vec_t v);
    reset_and_release(v);
    pwr_good = 1'b1;
    for (int k = 1; k <= RUN_K; k++) begin
      @(negedge clk);
      check_at(k, 1'b0, v, n_cs_n, n_oe_n, n_we_n, n_mode, n_rdy, n_addr, n_wdata);
      check_at(k, 1'b1, v, s_cs_n, s_oe_n, s_we_n, s_mode, s_rdy, s_addr, s_wdata);
      if (k == 3) begin
        // R9: inputs change after capture
        cfg_addr = v.addr_alt; cfg_data0 = v.d0_alt; cfg_data1 = v.d1_alt;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    pwr_good = 1'b0;
    cfg_addr = '0; cfg_data0 = '0; cfg_data1 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cs_n", 32'(n_cs_n), 32'd1);
    chk("R1", "oe_n", 32'(n_oe_n), 32'd1);
    chk("R1", "we_n", 32'(n_we_n), 32'd1);
    chk("R1", "ready", 32'(n_rdy), 32'd0);
    chk("R1", "mode", 32'(n_mode), 32'd0);
    chk("R10", "skip mode in reset", 32'(s_mode), 32'd1);

    foreach (VECS[i]) run_row(VECS[i]);

    // R2: idle while power-good stays low
    reset_and_release(VECS[2]);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R2", "cs_n", 32'(n_cs_n), 32'd1);
      chk("R2", "oe_n", 32'(n_oe_n), 32'd1);
      chk("R2", "mode", 32'(n_mode), 32'd0);
      chk("R2", "ready", 32'(n_rdy), 32'd0);
      chk("R2", "skip cs_n", 32'(s_cs_n), 32'd1);
    end

    // R1: asynchronous reset landing inside the first read
    pwr_good = 1'b1;
    repeat (B3N + 3) @(negedge clk);
    chk("R5", "cs_n before reset", 32'(n_cs_n), 32'd0);
    chk("R5", "oe_n before reset", 32'(n_oe_n), 32'd0);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R1", "async cs_n", 32'(n_cs_n), 32'd1);
    chk("R1", "async oe_n", 32'(n_oe_n), 32'd1);
    chk("R1", "async mode", 32'(n_mode), 32'd0);
    chk("R1", "async ready", 32'(n_rdy), 32'd0);
    chk("R10", "skip mode in reset", 32'(s_mode), 32'd1);
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule